// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the front end of an I2C target. It watches the SCL and SDA lines, which reach it already synchronized to the system clock. It finds START, repeated START and STOP conditions and decodes the address phase that follows each START. When the address belongs to it, the block acknowledges by pulling SDA low in the ninth clock slot. It then raises a flag that says it has been selected, together with the transfer direction. A general call is acknowledged too, but it is reported on its own flag.

A configuration input picks 7-bit or 10-bit addressing.

- **Writes in 10-bit mode:** a two-byte address must match before the block is selected.
- **Reads in 10-bit mode:** the two-byte match is remembered across a repeated START. A read can then be opened by sending only the first address byte again, this time with the read bit set.

After addressing, data moves as a plain byte handoff:

- Each byte received is presented for one clock on `rx_byte` with `rx_valid` high.
- For a read, the block shifts `tx_byte` out MSB first.
- At the end of every byte the block can hold SCL low until the host logic raises `host_ready`.

Both bus lines are modelled as open-drain: the block only ever drives a line low, through a drive-low enable.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset the block drives neither line low, and `addressed`, `gen_call`, `dir_read` and `rx_valid` are 0.
- R2: In 7-bit mode (`cfg_ten_bit`=0), an address byte whose upper seven bits equal `cfg_own_addr[6:0]` and whose bit 0 (R/W) is 0 is acknowledged. The block then sets `addressed`=1 and `dir_read`=0.
- R3: A matching 7-bit address byte with R/W=1 is acknowledged and sets `dir_read`=1. The block then sends `tx_byte` MSB first for each byte the controller reads. It stops driving SDA once the controller answers a byte with a not-acknowledge (SDA high in the ninth slot).
- R4: An address byte that matches neither the own address nor a general call gets no acknowledge, and `addressed` stays 0.
- R5: The byte 0x00 (address 0000000, write) is acknowledged as a general call. It sets `gen_call`=1 and leaves `addressed`=0. The two flags are never 1 together.
- R6: The 7-bit values 0000000, 0000010, 0000011, 11110xx and 11111xx are never acknowledged as an own address. This holds even when `cfg_own_addr` is set to one of them.
- R7: In 10-bit mode, the first byte 11110 followed by `cfg_own_addr[9:8]` and R/W=0 is acknowledged with `addressed` still 0. A second byte equal to `cfg_own_addr[7:0]` is then acknowledged and sets `addressed`=1, `dir_read`=0. A second byte that differs gets no acknowledge.
- R8: After a successful 10-bit two-byte match, a repeated START followed by the first byte with R/W=1 is acknowledged. It sets `addressed`=1 and `dir_read`=1, and `tx_byte` is sent.
- R9: A 10-bit first byte with R/W=1 that has no remembered match is not acknowledged. A STOP clears any remembered match.
- R10: Each data byte written to the selected block, or after a general call, is acknowledged. It appears on `rx_byte` with a one-cycle `rx_valid` pulse.
- R11: When `host_ready` is 0 at the end of the ninth bit of a byte in a data phase, `scl_drive_low` is held at 1. It is released one cycle after `host_ready` becomes 1.
- R12: A STOP clears `addressed` and `gen_call`. A START or repeated START clears them and restarts bit counting, even in the middle of a byte.
- R13: `sda_drive_low` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ten_bit | input | 1 | 0: 7-bit own address, 1: 10-bit own address |
| cfg_own_addr | input | 10 | Own address (bits 6:0 used in 7-bit mode) |
| host_ready | input | 1 | Host can accept or supply the next byte; 0 stretches SCL |
| tx_byte | input | 8 | Byte to send during a read |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| addressed | output | 1 | Selected by own address |
| dir_read | output | 1 | 1: controller reads from this block |
| gen_call | output | 1 | Selected by general call |
| rx_byte | output | 8 | Last data byte received |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |

## Verification
The address decoder is tried with a set of bytes that each separate one decision:

- **Own 7-bit address:** once with R/W=0 and once with R/W=1, which tells the write direction from the read direction.
- **Address one bit off from the own address:** shows that a near miss is refused.
- **0x00:** separates a general call from an own-address match.
- **Reserved codes loaded as the own address:** show that the reserved filter takes precedence over an equality match.

The 10-bit cases cover three sequences:

- A full write match.
- A wrong second byte.
- A read opened by a repeated START, tried once straight after a match and once after a STOP. This tells a remembered match from a fresh one.

Two more cases check bus handling. A repeated START cut into the middle of a data byte shows that bit counting restarts. A data byte sent while `host_ready` is low shows that the clock is held and then released.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;
   localparam int unsigned OWN_W  = 10;
   localparam int unsigned BYTE_W = 8;
   localparam logic [4:0]  TEN_PREFIX = 5'b11110;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR1,
      PH_ADDR2,
      PH_RX,
      PH_TX
   } phase_t;

   // 7-bit codes that must never be taken as an own address
   function automatic logic is_reserved7(input logic [6:0] a);
      return (a[6:3] == 4'b1111) || (a == 7'd0) || (a == 7'd2) || (a == 7'd3);
   endfunction
endpackage

// File: rtl/i2c_as_edges.sv
module i2c_as_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_in;
         sda_q <= sda_in;
      end
   end

   assign scl_rise  = scl_in & ~scl_q;
   assign scl_fall  = ~scl_in & scl_q;
   assign bus_start = scl_in & scl_q & sda_q & ~sda_in;
   assign bus_stop  = scl_in & scl_q & ~sda_q & sda_in;
endmodule

// File: rtl/i2c_as_bitcnt.sv
module i2c_as_bitcnt #(
   parameter int unsigned BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            restart,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            sda_in,
   output logic [BITS-1:0] byte_val,
   output logic            byte_done,
   output logic            data_fall,
   output logic            ack_fall,
   output logic            ack_rise,
   output logic            byte_end
);
   localparam int unsigned CW = $clog2(BITS + 2);
   localparam logic [CW-1:0] LAST_DATA = CW'(BITS - 1);
   localparam logic [CW-1:0] ACK_CNT   = CW'(BITS);
   localparam logic [CW-1:0] END_CNT   = CW'(BITS + 1);

   logic [CW-1:0]   cnt;
   logic [BITS-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (active) begin
         if (scl_rise && cnt <= ACK_CNT) begin
            cnt <= cnt + 1'b1;
            if (cnt < ACK_CNT) sh <= byte_val;
         end else if (scl_fall && cnt == END_CNT) begin
            cnt <= '0;
         end
      end
   end

   assign byte_val  = {sh[BITS-2:0], sda_in};
   assign byte_done = active & scl_rise & (cnt == LAST_DATA);
   assign data_fall = active & scl_fall & (cnt != '0) & (cnt < ACK_CNT);
   assign ack_fall  = active & scl_fall & (cnt == ACK_CNT);
   assign ack_rise  = active & scl_rise & (cnt == ACK_CNT);
   assign byte_end  = active & scl_fall & (cnt == END_CNT);
endmodule

// File: rtl/i2c_as_match.sv
module i2c_as_match
   import i2c_as_pkg::*;
#(
   parameter int unsigned GC_EN = 1
) (
   input  phase_t                phase_i,
   input  logic [BYTE_W-1:0]     byte_i,
   input  logic                  ten_mode_i,
   input  logic [OWN_W-1:0]      own_i,
   input  logic                  ten_match_i,
   output logic                  ack_o,
   output phase_t                nxt_o,
   output logic                  sel_o,
   output logic                  dir_o,
   output logic                  gc_o,
   output logic                  mem_set_o,
   output logic                  mem_clr_o
);
   logic [6:0] a7;
   logic       rw;
   logic       gc_hit;

   assign a7 = byte_i[7:1];
   assign rw = byte_i[0];

   generate
      if (GC_EN != 0) begin : g_gc
         assign gc_hit = (byte_i == '0);
      end else begin : g_nogc
         assign gc_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      ack_o     = 1'b0;
      nxt_o     = PH_IDLE;
      sel_o     = 1'b0;
      dir_o     = 1'b0;
      gc_o      = 1'b0;
      mem_set_o = 1'b0;
      mem_clr_o = 1'b0;
      if (phase_i == PH_ADDR1) begin
         mem_clr_o = 1'b1;
         if (gc_hit) begin
            ack_o = 1'b1;
            nxt_o = PH_RX;
            gc_o  = 1'b1;
         end else if (ten_mode_i) begin
            if (a7[6:2] == TEN_PREFIX && a7[1:0] == own_i[9:8]) begin
               if (!rw) begin
                  ack_o = 1'b1;
                  nxt_o = PH_ADDR2;
               end else if (ten_match_i) begin
                  ack_o = 1'b1;
                  nxt_o = PH_TX;
                  sel_o = 1'b1;
                  dir_o = 1'b1;
               end
            end
         end else if (!is_reserved7(a7) && a7 == own_i[6:0]) begin
            ack_o = 1'b1;
            nxt_o = rw ? PH_TX : PH_RX;
            sel_o = 1'b1;
            dir_o = rw;
         end
      end else if (phase_i == PH_ADDR2 && ten_mode_i && byte_i == own_i[7:0]) begin
         ack_o     = 1'b1;
         nxt_o     = PH_RX;
         sel_o     = 1'b1;
         mem_set_o = 1'b1;
      end
   end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
   import i2c_as_pkg::*;
#(
   parameter int unsigned TEN_BIT_EN = 1,
   parameter int unsigned GC_EN      = 1,
   parameter int unsigned STRETCH_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ten_bit,
   input  logic [OWN_W-1:0]  cfg_own_addr,
   input  logic              host_ready,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   output logic              addressed,
   output logic              dir_read,
   output logic              gen_call,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_valid
);
   generate
      if (TEN_BIT_EN > 1 || GC_EN > 1 || STRETCH_EN > 1) begin : g_bad_opt
         initial $error("i2c_addr_slave: option parameters must be 0 or 1");
      end
      if (BYTE_W != 8) begin : g_bad_w
         initial $error("i2c_addr_slave: byte width must be 8");
      end
   endgenerate

   phase_t            phase;
   logic              ten_mode, ten_match, ack_q, hold;
   logic [BYTE_W-1:0] tx_sh;
   logic              scl_rise, scl_fall, bus_start, bus_stop;
   logic [BYTE_W-1:0] byte_val;
   logic              byte_done, data_fall, ack_fall, ack_rise, byte_end;
   logic              m_ack, m_sel, m_dir, m_gc, m_set, m_clr;
   phase_t            m_nxt;
   logic              active, in_data, want_hold, do_load;

   generate
      if (TEN_BIT_EN != 0) begin : g_ten
         assign ten_mode = cfg_ten_bit;
      end else begin : g_seven
         assign ten_mode = 1'b0;
      end
      if (STRETCH_EN != 0) begin : g_str
         assign want_hold = ~host_ready;
      end else begin : g_nostr
         assign want_hold = 1'b0;
      end
   endgenerate

   assign active  = (phase != PH_IDLE);
   assign in_data = (phase == PH_RX) || (phase == PH_TX);
   assign do_load = (phase == PH_TX) &&
                    ((byte_end && !want_hold) || (hold && host_ready));

   i2c_as_edges u_edges (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop)
   );

   i2c_as_bitcnt #(.BITS(BYTE_W)) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .restart   (bus_start | bus_stop),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_in    (sda_in),
      .byte_val  (byte_val),
      .byte_done (byte_done),
      .data_fall (data_fall),
      .ack_fall  (ack_fall),
      .ack_rise  (ack_rise),
      .byte_end  (byte_end)
   );

   i2c_as_match #(.GC_EN(GC_EN)) u_match (
      .phase_i     (phase),
      .byte_i      (byte_val),
      .ten_mode_i  (ten_mode),
      .own_i       (cfg_own_addr),
      .ten_match_i (ten_match),
      .ack_o       (m_ack),
      .nxt_o       (m_nxt),
      .sel_o       (m_sel),
      .dir_o       (m_dir),
      .gc_o        (m_gc),
      .mem_set_o   (m_set),
      .mem_clr_o   (m_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase         <= PH_IDLE;
         ten_match     <= 1'b0;
         ack_q         <= 1'b0;
         hold          <= 1'b0;
         tx_sh         <= '0;
         sda_drive_low <= 1'b0;
         addressed     <= 1'b0;
         dir_read      <= 1'b0;
         gen_call      <= 1'b0;
         rx_byte       <= '0;
         rx_valid      <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (bus_stop || bus_start) begin
            phase         <= bus_stop ? PH_IDLE : PH_ADDR1;
            addressed     <= 1'b0;
            dir_read      <= 1'b0;
            gen_call      <= 1'b0;
            sda_drive_low <= 1'b0;
            hold          <= 1'b0;
            ack_q         <= 1'b0;
            if (bus_stop) ten_match <= 1'b0;
         end else begin
            if (byte_done) begin
               if (phase == PH_ADDR1 || phase == PH_ADDR2) begin
                  ack_q <= m_ack;
                  phase <= m_nxt;
                  if (m_sel) begin
                     addressed <= 1'b1;
                     dir_read  <= m_dir;
                  end
                  if (m_gc) gen_call <= 1'b1;
                  if (m_set) ten_match <= 1'b1;
                  else if (m_clr) ten_match <= 1'b0;
               end else if (phase == PH_RX) begin
                  ack_q    <= 1'b1;
                  rx_byte  <= byte_val;
                  rx_valid <= 1'b1;
               end else begin
                  ack_q <= 1'b0;
               end
            end
            if (data_fall && phase == PH_TX) begin
               sda_drive_low <= ~tx_sh[BYTE_W-2];
               tx_sh         <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
            if (ack_fall) sda_drive_low <= ack_q;
            if (ack_rise && phase == PH_TX && sda_in) phase <= PH_IDLE;
            if (byte_end) begin
               sda_drive_low <= 1'b0;
               ack_q         <= 1'b0;
               if (in_data && want_hold) hold <= 1'b1;
            end
            if (hold && host_ready) hold <= 1'b0;
            if (do_load) begin
               tx_sh         <= tx_byte;
               sda_drive_low <= ~tx_byte[BYTE_W-1];
            end
         end
      end
   end

   assign scl_drive_low = hold;
endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_in,
   input logic sda_in,
   input logic host_ready,
   input logic scl_drive_low,
   input logic sda_drive_low,
   input logic addressed,
   input logic gen_call,
   input logic rx_valid
);
   logic scl_d, sda_d, stop_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_in;
         sda_d <= sda_in;
      end
   end
   assign stop_seen = scl_in & scl_d & sda_in & ~sda_d;

   a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      scl_drive_low && !host_ready |=> scl_drive_low);
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      scl_drive_low && host_ready |=> !scl_drive_low);
   a_r5_gc_not_own: assert property (@(posedge clk) disable iff (!rst_n)
      !(addressed && gen_call));
   a_r12_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> !addressed && !gen_call);
   a_r13_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> !scl_in);
   a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
endmodule

bind i2c_addr_slave i2c_addr_slave_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_in        (scl_in),
   .sda_in        (sda_in),
   .host_ready    (host_ready),
   .scl_drive_low (scl_drive_low),
   .sda_drive_low (sda_drive_low),
   .addressed     (addressed),
   .gen_call      (gen_call),
   .rx_valid      (rx_valid)
);

// File: tb/i2c_addr_slave_tb_top.sv
module i2c_addr_slave_tb_top;
   localparam int Q = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_ten_bit = 1'b0;
   logic [9:0] cfg_own_addr = 10'h03A;
   logic host_ready = 1'b1;
   logic [7:0] tx_byte = 8'hA5;
   logic m_scl_low = 1'b0;
   logic m_sda_low = 1'b0;
   logic scl_bus, sda_bus;
   logic scl_drive_low, sda_drive_low, addressed, dir_read, gen_call, rx_valid;
   logic [7:0] rx_byte;

   int total = 0;
   int bad = 0;
   int r13_viol = 0;
   logic [7:0] exp_q[$];

   always #10 clk = ~clk;

   assign scl_bus = ~(m_scl_low | scl_drive_low);
   assign sda_bus = ~(m_sda_low | sda_drive_low);

   i2c_addr_slave dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_ten_bit   (cfg_ten_bit),
      .cfg_own_addr  (cfg_own_addr),
      .host_ready    (host_ready),
      .tx_byte       (tx_byte),
      .scl_in        (scl_bus),
      .sda_in        (sda_bus),
      .scl_drive_low (scl_drive_low),
      .sda_drive_low (sda_drive_low),
      .addressed     (addressed),
      .dir_read      (dir_read),
      .gen_call      (gen_call),
      .rx_byte       (rx_byte),
      .rx_valid      (rx_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor (R10)
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R10 unexpected byte", rx_byte, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rx_byte == e, "R10 rx byte", rx_byte, e);
         end
      end
   end

   // R13 monitor
   logic sda_dl_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_drive_low != sda_dl_prev && scl_bus) r13_viol++;
      sda_dl_prev <= sda_drive_low;
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_high();
      int n = 0;
      while (!scl_bus && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic m_start();
      m_sda_low = 1'b0; wq(Q);
      m_scl_low = 1'b0; wait_scl_high(); wq(Q);
      m_sda_low = 1'b1; wq(Q);
      m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1; wq(Q);
      m_scl_low = 1'b0; wait_scl_high(); wq(Q);
      m_sda_low = 1'b0; wq(Q);
   endtask

   task automatic m_wbit(input logic b);
      m_sda_low = ~b; wq(Q);
      m_scl_low = 1'b0; wait_scl_high(); wq(2 * Q);
      m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic m_rbit(output logic b);
      m_sda_low = 1'b0; wq(Q);
      m_scl_low = 1'b0; wait_scl_high(); wq(Q);
      b = sda_bus; wq(Q);
      m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic m_wbyte(input logic [7:0] d, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) m_wbit(d[i]);
      m_rbit(b);
      acked = ~b;
   endtask

   task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         m_rbit(b);
         d[i] = b;
      end
      m_wbit(~give_ack);
      m_sda_low = 1'b0;
   endtask

   task automatic send_data(input logic [7:0] d, input string req);
      logic a;
      exp_q.push_back(d);
      m_wbyte(d, a);
      chk(a, req, a, 1);
   endtask

   task automatic run_all();
      logic a;
      logic [7:0] d;
      rst_n = 1'b0; wq(4);
      rst_n = 1'b1; wq(2);
      // R1
      chk(!addressed && !gen_call && !dir_read && !rx_valid, "R1 reset flags",
          {addressed, gen_call, dir_read, rx_valid}, 0);
      chk(!scl_drive_low && !sda_drive_low, "R1 reset drive", {scl_drive_low, sda_drive_low}, 0);

      // R2 + R10
      m_start(); m_wbyte(8'h74, a);
      chk(a, "R2 ack", a, 1);
      chk(addressed && !dir_read, "R2 flags", {addressed, dir_read}, 2'b10);
      send_data(8'h55, "R10 ack 55");
      send_data(8'hC3, "R10 ack C3");
      m_stop(); wq(2);
      chk(!addressed, "R12 stop clears", addressed, 0);

      // R4 near miss
      m_start(); m_wbyte(8'h76, a);
      chk(!a, "R4 nack", a, 0);
      chk(!addressed, "R4 not addressed", addressed, 0);
      m_stop();

      // R3 read
      tx_byte = 8'hA5;
      m_start(); m_wbyte(8'h75, a);
      chk(a && addressed && dir_read, "R3 read addr", {a, addressed, dir_read}, 3'b111);
      tx_byte = 8'h3C;
      m_rbyte(1'b1, d);
      chk(d == 8'hA5, "R3 first byte", d, 8'hA5);
      m_rbyte(1'b0, d);
      chk(d == 8'h3C, "R3 second byte", d, 8'h3C);
      wq(Q);
      chk(!sda_drive_low, "R3 released after nack", sda_drive_low, 0);
      m_stop();

      // R5 general call
      m_start(); m_wbyte(8'h00, a);
      chk(a && gen_call && !addressed, "R5 general call", {a, gen_call, addressed}, 3'b110);
      send_data(8'h06, "R10 gc data");
      m_stop(); wq(2);
      chk(!gen_call, "R12 stop clears gc", gen_call, 0);

      // R6 reserved own addresses
      cfg_own_addr = 10'h002;
      m_start(); m_wbyte(8'h04, a); chk(!a, "R6 0000010", a, 0); m_stop();
      cfg_own_addr = 10'h07C;
      m_start(); m_wbyte(8'hF8, a); chk(!a, "R6 11111xx", a, 0); m_stop();
      cfg_own_addr = 10'h078;
      m_start(); m_wbyte(8'hF0, a); chk(!a, "R6 11110xx 7-bit", a, 0); m_stop();
      chk(!addressed, "R6 not addressed", addressed, 0);

      // R7 10-bit write
      cfg_ten_bit = 1'b1; cfg_own_addr = 10'h2B5;
      m_start(); m_wbyte(8'hF4, a);
      chk(a && !addressed, "R7 first byte", {a, addressed}, 2'b10);
      m_wbyte(8'hB5, a);
      chk(a && addressed && !dir_read, "R7 second byte", {a, addressed, dir_read}, 3'b110);
      send_data(8'h9E, "R10 10-bit data");
      // R8 repeated start read
      tx_byte = 8'h5A;
      m_start();
      chk(!addressed, "R12 restart clears", addressed, 0);
      m_wbyte(8'hF5, a);
      chk(a && addressed && dir_read, "R8 read resend", {a, addressed, dir_read}, 3'b111);
      m_rbyte(1'b0, d);
      chk(d == 8'h5A, "R8 tx byte", d, 8'h5A);
      m_stop();
      // R9 after stop
      m_start(); m_wbyte(8'hF5, a);
      chk(!a && !addressed, "R9 no memory", {a, addressed}, 0);
      m_stop();
      // R7 wrong second byte
      m_start(); m_wbyte(8'hF4, a); m_wbyte(8'hB4, a);
      chk(!a && !addressed, "R7 wrong low byte", {a, addressed}, 0);
      m_stop();

      // R11 stretch
      cfg_ten_bit = 1'b0; cfg_own_addr = 10'h03A;
      m_start(); m_wbyte(8'h74, a);
      host_ready = 1'b0;
      send_data(8'h42, "R11 data ack");
      chk(scl_drive_low && !scl_bus, "R11 held", {scl_drive_low, scl_bus}, 2'b10);
      wq(40);
      chk(scl_drive_low, "R11 still held", scl_drive_low, 1);
      host_ready = 1'b1; wq(3);
      chk(!scl_drive_low, "R11 released", scl_drive_low, 0);
      m_stop();

      // R12 repeated start mid-byte
      m_start(); m_wbyte(8'h74, a);
      for (int i = 0; i < 4; i++) m_wbit(1'b1);
      m_start();
      m_wbyte(8'h74, a);
      chk(a && addressed, "R12 count restart", {a, addressed}, 2'b11);
      send_data(8'h11, "R12 byte after restart");
      m_stop(); wq(4);

      chk(exp_q.size() == 0, "R10 all bytes seen", exp_q.size(), 0);
      chk(r13_viol == 0, "R13 sda change while scl high", r13_viol, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule